// File: doc/BRIEF.md
# Cascadable Presettable Down Counter

A chain of binary down-counting digits, each `DIGIT_W` bits wide, that acts as a programmable divide-by-N. The block runs from one system clock. The count clock and the inhibit line are treated as ordinary data inputs: each goes through a synchronizer and an edge detector. A count event is either a rising edge of the count clock while inhibit is low, or a falling edge of inhibit while the count clock is high. Each event lowers the multi-digit count by one, with a borrow passing from each digit to the next more significant one.

Every digit drives a zero flag. That flag is high only when the digit reads zero and the digit's cascade-feedback input is high. The most significant digit has its feedback tied high. Each lower digit takes its feedback from the zero flag of the digit above it. As a result, the zero flag of the least significant digit is high only when the whole count is zero. That flag is the block's `zero_out`, and it also drives the preset enable of every digit.

When the count reaches zero, all digits reload the preset word on the next system clock. `zero_out` therefore gives one pulse, one system clock wide, for every N count events.

Top module: `pdc_chain`

## Requirements
- R1: While clear and preset enable are both low, each count event (a count-clock rise with inhibit low) lowers the full count by exactly one.
- R2: A rising count-clock edge that arrives while inhibit is high leaves the count unchanged.
- R3: With the count clock held high, each falling edge of inhibit lowers the count by one. A falling edge of inhibit while the count clock is low leaves the count unchanged.
- R4: While `clear` is high, every count bit reads zero. This holds whatever the count events and the preset word are doing.
- R5: While clear is low and a digit's preset enable is high, that digit loads its slice of `preset_word` on the next system clock. Bit 0 of each slice is the least significant bit, and digit 0 occupies the lowest bits.
- R6: A digit's zero flag is high only while its cascade feedback is high and its count is zero. As a result, `zero_out` high implies that `count` is all zeros.
- R7: While `clear` is high, `zero_out` is high, because the top digit's feedback is tied high and every digit reads zero.
- R8: Because `zero_out` drives preset enable, the block reloads N when it reaches zero. `zero_out` gives one pulse, one system clock wide, every N count events, including N = 1. After K events from a load of N, the count reads N - (K mod N).
- R9: A digit that counts down from zero wraps to all ones and borrows one from the next digit. For example, 0x010 becomes 0x00F.
- R10: Digit i takes its cascade feedback from the zero flag of digit i+1, and the top digit's feedback is tied high. A count whose lowest digits are zero but whose upper digits are not zero, such as 0x100, keeps `zero_out` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| clear | input | 1 | Asynchronous clear, active high; forces the count to zero |
| cnt_clk | input | 1 | Count clock, sampled and edge-detected |
| inhibit | input | 1 | Blocks count-clock rises; its falling edge counts while cnt_clk is high |
| preset_word | input | NUM_STAGES*DIGIT_W | Value N that is reloaded when the count reaches zero |
| count | output | NUM_STAGES*DIGIT_W | Current count, digit 0 in the lowest bits |
| zero_out | output | 1 | Terminal-count flag of the least significant digit |

## Verification
The bench builds two instances. The first has three 4-bit digits, which gives a 12-bit divider. With it, the bench reaches the borrow across digit boundaries, the wrap from 0x010 to 0x00F, and the state 0x100, where the lower digits are zero but the cascade keeps `zero_out` low. It also runs divide-by-N for values from 1 up to 0x100. The second instance has a single digit, which shows the same reload loop when only the tied-high feedback is present. Both instances use the default two-flop synchronizer.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_DEC  = 2'd1,
    ACT_LOAD = 2'd2
  } digit_act_t;

  // Preset enable wins over a count event.
  function automatic digit_act_t pick_act(input logic preset_en, input logic count_evt);
    if (preset_en)      return ACT_LOAD;
    else if (count_evt) return ACT_DEC;
    else                return ACT_HOLD;
  endfunction

endpackage

// File: rtl/pdc_edge.sv
module pdc_edge #(
  parameter int   SYNC_STAGES = 2,
  parameter bit   RISING      = 1'b1,
  parameter logic RESET_VAL   = 1'b0
) (
  input  logic clk,
  input  logic clear,
  input  logic din,
  output logic level,
  output logic pulse
);

  localparam int DEPTH = SYNC_STAGES + 1;

  logic [DEPTH-1:0] shift_q;

  always_ff @(posedge clk or posedge clear) begin
    if (clear) shift_q <= {DEPTH{RESET_VAL}};
    else       shift_q <= {shift_q[DEPTH-2:0], din};
  end

  assign level = shift_q[SYNC_STAGES-1];

  generate
    if (RISING) begin : g_rise
      assign pulse = shift_q[SYNC_STAGES-1] & ~shift_q[SYNC_STAGES];
    end else begin : g_fall
      assign pulse = ~shift_q[SYNC_STAGES-1] & shift_q[SYNC_STAGES];
    end
  endgenerate

  // A pulse marks a change of the synchronized level since the last cycle.
  assert_edge_change_R3: assert property (@(posedge clk) disable iff (clear)
    pulse |-> (level != $past(level)));

endmodule

// File: rtl/pdc_event.sv
module pdc_event #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic clear,
  input  logic cnt_clk,
  input  logic inhibit,
  output logic count_evt
);

  logic clk_level, clk_rise;
  logic inh_level, inh_fall;

  pdc_edge #(.SYNC_STAGES(SYNC_STAGES), .RISING(1'b1), .RESET_VAL(1'b1)) u_clk_edge (
    .clk(clk), .clear(clear), .din(cnt_clk), .level(clk_level), .pulse(clk_rise)
  );

  pdc_edge #(.SYNC_STAGES(SYNC_STAGES), .RISING(1'b0), .RESET_VAL(1'b0)) u_inh_edge (
    .clk(clk), .clear(clear), .din(inhibit), .level(inh_level), .pulse(inh_fall)
  );

  assign count_evt = (clk_rise & ~inh_level) | (inh_fall & clk_level);

endmodule

// File: rtl/pdc_digit.sv
module pdc_digit #(
  parameter int DIGIT_W = 4
) (
  input  logic               clk,
  input  logic               clear,
  input  logic               count_evt,
  input  logic               preset_en,
  input  logic               cascade_fb,
  input  logic [DIGIT_W-1:0] preset_val,
  output logic [DIGIT_W-1:0] q,
  output logic               zero_flag
);
  import pdc_pkg::*;

  localparam logic [DIGIT_W-1:0] ONE = DIGIT_W'(1);

  function automatic logic [DIGIT_W-1:0] step_down(input logic [DIGIT_W-1:0] v);
    return v - ONE;
  endfunction

  digit_act_t act;
  assign act = pick_act(preset_en, count_evt);

  always_ff @(posedge clk or posedge clear) begin
    if (clear) begin
      q <= '0;
    end else begin
      case (act)
        ACT_LOAD: q <= preset_val;
        ACT_DEC:  q <= step_down(q);
        default:  q <= q;
      endcase
    end
  end

  assign zero_flag = cascade_fb & (q == '0);

  assert_clear_zero_R4: assert property (@(posedge clk)
    clear |-> (q == '0));

  assert_load_R5: assert property (@(posedge clk) disable iff (clear)
    (!clear && preset_en) |=> (q == $past(preset_val)));

  assert_step_R1: assert property (@(posedge clk) disable iff (clear)
    (!clear && !preset_en && count_evt) |=> (q == step_down($past(q))));

  assert_hold_R2: assert property (@(posedge clk) disable iff (clear)
    (!clear && !preset_en && !count_evt) |=> $stable(q));

endmodule

// File: rtl/pdc_chain.sv
module pdc_chain #(
  parameter int NUM_STAGES  = 3,
  parameter int DIGIT_W     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          clear,
  input  logic                          cnt_clk,
  input  logic                          inhibit,
  input  logic [NUM_STAGES*DIGIT_W-1:0] preset_word,
  output logic [NUM_STAGES*DIGIT_W-1:0] count,
  output logic                          zero_out
);

  localparam int TOTAL_W = NUM_STAGES * DIGIT_W;

  logic                  count_evt;
  logic                  preset_en;
  logic [NUM_STAGES:0]   zero_flag;
  logic [NUM_STAGES-1:0] borrow;

  pdc_event #(.SYNC_STAGES(SYNC_STAGES)) u_event (
    .clk(clk), .clear(clear), .cnt_clk(cnt_clk), .inhibit(inhibit), .count_evt(count_evt)
  );

  // Feedback of the top digit is tied high; the lowest flag drives preset.
  assign zero_flag[NUM_STAGES] = 1'b1;
  assign preset_en             = zero_flag[0];
  assign zero_out              = zero_flag[0];
  assign borrow[0]             = 1'b1;

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
    pdc_digit #(.DIGIT_W(DIGIT_W)) u_digit (
      .clk        (clk),
      .clear      (clear),
      .count_evt  (count_evt & borrow[i]),
      .preset_en  (preset_en),
      .cascade_fb (zero_flag[i+1]),
      .preset_val (preset_word[i*DIGIT_W +: DIGIT_W]),
      .q          (count[i*DIGIT_W +: DIGIT_W]),
      .zero_flag  (zero_flag[i])
    );
    if (i < NUM_STAGES - 1) begin : g_borrow
      assign borrow[i+1] = borrow[i] & (count[i*DIGIT_W +: DIGIT_W] == '0);
    end
  end

  assert_zero_whole_R10: assert property (@(posedge clk) disable iff (clear)
    zero_out |-> (count == {TOTAL_W{1'b0}}));

  assert_reload_R8: assert property (@(posedge clk) disable iff (clear)
    (!clear && zero_out) |=> (count == $past(preset_word)));

  assert_clear_flag_R7: assert property (@(posedge clk)
    clear |-> zero_out);

endmodule

// File: tb/sim_pdc_chain.sv
module sim_pdc_chain;

  logic        clk = 1'b0;
  logic        clear = 1'b1;
  logic        cnt_clk = 1'b0;
  logic        inhibit = 1'b0;
  logic [11:0] preset_a = 12'h000;
  logic [3:0]  preset_b = 4'h0;
  logic [11:0] count_a;
  logic [3:0]  count_b;
  logic        zero_a, zero_b;

  int total = 0;
  int bad = 0;
  int pulses_a = 0, pulses_b = 0, hi_b = 0, viol = 0;
  logic prev_a = 1'b0, prev_b = 1'b0;

  always #5 clk = ~clk;

  pdc_chain #(.NUM_STAGES(3), .DIGIT_W(4)) u0 (
    .clk(clk), .clear(clear), .cnt_clk(cnt_clk), .inhibit(inhibit),
    .preset_word(preset_a), .count(count_a), .zero_out(zero_a)
  );

  pdc_chain #(.NUM_STAGES(1), .DIGIT_W(4)) u1 (
    .clk(clk), .clear(clear), .cnt_clk(cnt_clk), .inhibit(inhibit),
    .preset_word(preset_b), .count(count_b), .zero_out(zero_b)
  );

  // Pulse counting and the R6 relation, sampled between edges.
  always @(negedge clk) begin
    if (zero_a && !prev_a) pulses_a++;
    if (zero_b && !prev_b) pulses_b++;
    if (zero_b) hi_b++;
    if (!clear && ((zero_a && count_a != 12'h000) || (zero_b && count_b != 4'h0))) viol++;
    prev_a <= zero_a;
    prev_b <= zero_b;
  end

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_event();
    @(negedge clk) cnt_clk = 1'b1;
    idle(5);
    cnt_clk = 1'b0;
    idle(5);
  endtask

  task automatic do_reset(input logic [11:0] na, input logic [3:0] nb);
    @(negedge clk);
    clear = 1'b1; preset_a = na; preset_b = nb;
    cnt_clk = 1'b0; inhibit = 1'b0;
    idle(3);
    clear = 1'b0;
    idle(4);
  endtask

  task automatic test_reset();
    @(negedge clk);
    clear = 1'b1; preset_a = 12'hABC;
    idle(2);
    chk("R4 count zero in clear", count_a, 12'h000);
    chk("R7 zero_out high in clear", {11'd0, zero_a}, 12'h001);
    clk_event();
    clk_event();
    chk("R4 clear overrides events", count_a, 12'h000);
    clear = 1'b0;
    idle(4);
    chk("R5 preset loaded after clear", count_a, 12'hABC);
  endtask

  task automatic test_step_and_inhibit();
    do_reset(12'h123, 4'h0);
    repeat (5) clk_event();
    chk("R1 five decrements", count_a, 12'h11E);
    inhibit = 1'b1;
    idle(5);
    repeat (3) clk_event();
    chk("R2 inhibited rises ignored", count_a, 12'h11E);
    cnt_clk = 1'b1;
    idle(5);
    repeat (3) begin
      inhibit = 1'b0; idle(5);
      inhibit = 1'b1; idle(5);
    end
    chk("R3 inhibit falls count with clock high", count_a, 12'h11B);
    cnt_clk = 1'b0; idle(5);
    inhibit = 1'b0; idle(5);
    chk("R3 inhibit fall with clock low ignored", count_a, 12'h11B);
  endtask

  task automatic test_wrap();
    do_reset(12'h010, 4'h0);
    chk("R10 0x010 keeps zero_out low", {11'd0, zero_a}, 12'h000);
    clk_event();
    chk("R9 wrap with borrow", count_a, 12'h00F);
  endtask

  task automatic test_cascade();
    do_reset(12'h100, 4'h0);
    chk("R10 count 0x100 loaded", count_a, 12'h100);
    chk("R10 upper digit nonzero blocks zero_out", {11'd0, zero_a}, 12'h000);
  endtask

  task automatic div_run(input int n, input int k);
    int base;
    do_reset(12'(n), 4'h0);
    base = pulses_a;
    repeat (k) clk_event();
    chk($sformatf("R8 pulses N=%0d K=%0d", n, k), 12'(pulses_a - base), 12'(k / n));
    chk($sformatf("R8 residue N=%0d K=%0d", n, k), count_a, 12'(n - (k % n)));
  endtask

  task automatic test_single();
    int base, hbase;
    do_reset(12'h001, 4'h5);
    base = pulses_b;
    hbase = hi_b;
    repeat (12) clk_event();
    chk("R8 single digit pulses", 12'(pulses_b - base), 12'd2);
    chk("R8 single digit pulse width one cycle", 12'(hi_b - hbase), 12'd2);
    chk("R8 single digit residue", {8'd0, count_b}, 12'h003);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    idle(3);
    test_reset();
    test_step_and_inhibit();
    test_wrap();
    test_cascade();
    div_run(1, 5);
    div_run(3, 10);
    div_run(17, 40);
    div_run(256, 259);
    test_single();
    chk("R6 zero_out only at count zero", 12'(viol), 12'd0);
    summary();
    $finish;
  end

endmodule